// File: doc/BRIEF.md
# Modbus RTU Frame Delimiter with CRC Check

This block sits behind a UART receiver on a half-duplex serial bus. It takes each received byte, any framing-error and overrun flags that come with it, and a strobe that pulses once per bit time at the current baud rate. It finds where a frame ends by measuring how long the line has been silent since the last byte. Silence is counted in character times, so the same logic works at any baud rate without retuning.

Once a frame has ended, the block checks the CRC-16 that the frame carries in its last two bytes. It then gives a single-cycle completion strobe. The strobe carries the byte count, a CRC-good verdict and the framing and overrun flags gathered during the frame. A line error is never folded into the CRC verdict. The block stores no payload and does not decode addresses or functions.

Top module: `rtu_frame_delim`

## Requirements
- R1: After reset, `frame_done_o`, `frame_len_o`, `crc_ok_o`, `frame_err_o` and `overrun_o` are all zero.
- R2: Silence is measured in half-character units. With `BITS_PER_CHAR` bit ticks per character, one unit passes for every `BITS_PER_CHAR/2` ticks. A frame ends once 7 units (3.5 characters) have passed since the last byte. With the default of 11 bits, `frame_done_o` rises in the cycle right after the 39th bit tick of silence.
- R3: A gap shorter than the threshold does not end a frame. With the default, this is up to 38 bit ticks between bytes. Bytes on both sides of such a gap count toward one frame.
- R4: Only bit ticks advance the silence count. Any number of clock cycles without a bit tick never ends a frame.
- R5: The CRC is CRC-16 with reflected polynomial 0xA001 and initial value 0xFFFF. It is sent low byte first. `crc_ok_o` is 1 only when running the CRC over every byte of the frame, CRC bytes included, leaves zero.
- R6: A frame of fewer than 4 bytes always reports `crc_ok_o` = 0, even if its CRC remainder is zero (for example the two-byte frame 0xFF 0xFF).
- R7: `frame_done_o` is high for exactly one clock per frame. `frame_len_o` gives the number of bytes received in that frame.
- R8: If any byte of the frame arrived with the framing-error input set, `frame_err_o` is 1 at completion. This flag does not change `crc_ok_o`.
- R9: If any byte of the frame arrived with the overrun input set, `overrun_o` is 1 at completion. This flag does not change `crc_ok_o`.
- R10: The CRC, the length and both flags start fresh for each frame. Nothing carries over from the frame before.
- R11: Bit ticks with no byte received since the last completion never produce `frame_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time at the line baud rate |
| rx_valid_i | input | 1 | Received byte valid strobe |
| rx_data_i | input | 8 | Received byte |
| rx_frame_err_i | input | 1 | Stop-bit error on the byte, sampled with `rx_valid_i` |
| rx_overrun_i | input | 1 | Receiver overrun on the byte, sampled with `rx_valid_i` |
| frame_done_o | output | 1 | Frame completion strobe, one clock |
| frame_len_o | output | LEN_W | Byte count of the completed frame, saturating |
| crc_ok_o | output | 1 | CRC remainder zero and length at least 4 |
| frame_err_o | output | 1 | Framing error seen during the frame |
| overrun_o | output | 1 | Overrun seen during the frame |

## Verification
Some properties are checked on every cycle. The completion strobe is always a single cycle. It never follows a received byte directly. It never reports an empty frame. A good CRC verdict always comes with a length of at least four.

Other behaviour can only be shown by the bench's scenarios. These are the exact tick count at which the 3.5-character boundary fires, that gaps one tick shorter merge bytes into one frame, and that the CRC value follows the polynomial. They also cover the short frame whose remainder is zero, line-error flags that stay sticky beside a good CRC, and the clearing of every field between frames.

// File: rtl/rtu_frame_pkg.sv
package rtu_frame_pkg;
  localparam logic [15:0] CRC_POLY = 16'hA001;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;

  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] data);
    logic [15:0] r;
    r = crc ^ {8'h00, data};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
  parameter int BITS_PER_CHAR = 11,
  parameter int EOF_UNITS     = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic byte_i,
  output logic eof_o
);
  localparam int ACC_W  = $clog2(BITS_PER_CHAR + 2);
  localparam int UNIT_W = $clog2(EOF_UNITS + 1);

  logic              armed_q;
  logic [ACC_W-1:0]  acc_q, acc_sum;
  logic [UNIT_W-1:0] units_q;
  logic              unit_step;

  // two half-steps per bit tick; one unit each BITS_PER_CHAR half-steps
  assign acc_sum   = acc_q + ACC_W'(2);
  assign unit_step = acc_sum >= ACC_W'(BITS_PER_CHAR);
  assign eof_o     = armed_q && !byte_i && bit_tick_i && unit_step &&
                     (units_q == UNIT_W'(EOF_UNITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      acc_q   <= '0;
      units_q <= '0;
    end else if (byte_i) begin
      armed_q <= 1'b1;
      acc_q   <= '0;
      units_q <= '0;
    end else if (bit_tick_i && armed_q) begin
      if (eof_o) begin
        armed_q <= 1'b0;
        acc_q   <= '0;
        units_q <= '0;
      end else begin
        acc_q   <= unit_step ? acc_sum - ACC_W'(BITS_PER_CHAR) : acc_sum;
        units_q <= units_q + UNIT_W'(unit_step);
      end
    end
  end
endmodule

// File: rtl/rtu_crc_acc.sv
module rtu_crc_acc
  import rtu_frame_pkg::*;
#(
  parameter int LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_i,
  input  logic [7:0]       data_i,
  input  logic             ferr_i,
  input  logic             ovr_i,
  input  logic             clear_i,
  output logic [15:0]      crc_o,
  output logic [LEN_W-1:0] len_o,
  output logic             ferr_o,
  output logic             ovr_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_o  <= CRC_INIT;
      len_o  <= '0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (clear_i) begin
      crc_o  <= CRC_INIT;
      len_o  <= '0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
    end else if (byte_i) begin
      crc_o  <= crc16_step(crc_o, data_i);
      if (len_o != LEN_MAX) len_o <= len_o + 1'b1;
      ferr_o <= ferr_o | ferr_i;
      ovr_o  <= ovr_o | ovr_i;
    end
  end
endmodule

// File: rtl/rtu_frame_delim.sv
module rtu_frame_delim #(
  parameter int BITS_PER_CHAR = 11,
  parameter int EOF_UNITS     = 7,
  parameter int LEN_W         = 9,
  parameter int MIN_LEN       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_tick_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_data_i,
  input  logic             rx_frame_err_i,
  input  logic             rx_overrun_i,
  output logic             frame_done_o,
  output logic [LEN_W-1:0] frame_len_o,
  output logic             crc_ok_o,
  output logic             frame_err_o,
  output logic             overrun_o
);
  logic             eof;
  logic [15:0]      crc_rem;
  logic [LEN_W-1:0] len;
  logic             ferr, ovr;

  rtu_gap_timer #(.BITS_PER_CHAR(BITS_PER_CHAR), .EOF_UNITS(EOF_UNITS)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .byte_i     (rx_valid_i),
    .eof_o      (eof)
  );

  rtu_crc_acc #(.LEN_W(LEN_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .byte_i  (rx_valid_i),
    .data_i  (rx_data_i),
    .ferr_i  (rx_frame_err_i),
    .ovr_i   (rx_overrun_i),
    .clear_i (eof),
    .crc_o   (crc_rem),
    .len_o   (len),
    .ferr_o  (ferr),
    .ovr_o   (ovr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_done_o <= 1'b0;
      frame_len_o  <= '0;
      crc_ok_o     <= 1'b0;
      frame_err_o  <= 1'b0;
      overrun_o    <= 1'b0;
    end else begin
      frame_done_o <= eof;
      if (eof) begin
        frame_len_o <= len;
        crc_ok_o    <= (crc_rem == 16'h0000) && (len >= LEN_W'(MIN_LEN));
        frame_err_o <= ferr;
        overrun_o   <= ovr;
      end
    end
  end
endmodule

// File: rtl/rtu_frame_delim_chk.sv
module rtu_frame_delim_chk #(
  parameter int LEN_W   = 9,
  parameter int MIN_LEN = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_tick_i,
  input logic             rx_valid_i,
  input logic [7:0]       rx_data_i,
  input logic             rx_frame_err_i,
  input logic             rx_overrun_i,
  input logic             frame_done_o,
  input logic [LEN_W-1:0] frame_len_o,
  input logic             crc_ok_o,
  input logic             frame_err_o,
  input logic             overrun_o
);
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  // R3
  byte_blocks_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> !frame_done_o);

  // R11
  done_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (frame_len_o != '0));

  // R6
  short_never_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_o && crc_ok_o) |-> (frame_len_o >= LEN_W'(MIN_LEN)));
endmodule

bind rtu_frame_delim rtu_frame_delim_chk #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_chk (.*);

// File: tb/rtu_frame_delim_tb.sv
module rtu_frame_delim_tb;
  localparam int BITS  = 11;
  localparam int LEN_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, rx_valid = 1'b0, ferr = 1'b0, ovr = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic done, crc_ok, ferr_o, ovr_o;
  logic [LEN_W-1:0] len_o;

  int n_chk = 0, n_fail = 0, exp_ticks;
  bit finished = 0;
  logic [7:0] fb[0:31];

  always #10 clk = ~clk;

  rtu_frame_delim u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_frame_err_i(ferr), .rx_overrun_i(ovr),
    .frame_done_o(done), .frame_len_o(len_o), .crc_ok_o(crc_ok),
    .frame_err_o(ferr_o), .overrun_o(ovr_o)
  );

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {8'h00, fb[k]};
      for (int b = 0; b < 8; b++) begin
        if (c[0]) c = (c >> 1) ^ 16'hA001;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic fe, input logic ov);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; ferr = fe; ovr = ov;
    @(negedge clk);
    rx_valid = 1'b0; ferr = 1'b0; ovr = 1'b0;
  endtask

  task automatic tick_once(output logic d);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    d = done;
  endtask

  task automatic quiet_gap(input int n, input string req);
    logic d;
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      tick_once(d);
      if (d) seen = 1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic close_frame(input int n, input logic efe, input logic eov, input string req);
    logic d = 1'b0;
    int t = 0;
    logic exp_ok;
    exp_ok = (n >= 4) && (ref_crc(n) == 16'h0000);
    while (!d && t < 60) begin tick_once(d); t++; end
    check(t == exp_ticks, {req, " R2 eof tick"}, t, exp_ticks);
    check(len_o == LEN_W'(n), {req, " R7 len"}, int'(len_o), n);
    check(crc_ok == exp_ok, {req, " R5 crc_ok"}, crc_ok, exp_ok);
    check(ferr_o == efe, {req, " R8 ferr"}, ferr_o, efe);
    check(ovr_o == eov, {req, " R9 ovr"}, ovr_o, eov);
    @(negedge clk);
    check(done == 1'b0, {req, " R7 pulse"}, done, 0);
  endtask

  // sends fb[0:n-1] with gaps below the threshold
  task automatic push_frame(input int n, input int max_gap, input int fe_at, input int ov_at);
    for (int k = 0; k < n; k++) begin
      send(fb[k], k == fe_at, k == ov_at);
      if (k != n - 1) quiet_gap($urandom_range(0, max_gap), "R3 gap");
    end
  endtask

  task automatic build(input int nd, input bit good);
    logic [15:0] c;
    for (int k = 0; k < nd; k++) fb[k] = 8'($urandom);
    c = ref_crc(nd);
    if (!good) c = c ^ 16'h5A00;
    fb[nd] = c[7:0]; fb[nd+1] = c[15:8];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_ticks = 0;
    while (((2 * exp_ticks) / BITS) < 7) exp_ticks++;

    repeat (3) @(negedge clk);
    // R1
    check(done == 0 && len_o == 0 && crc_ok == 0 && ferr_o == 0 && ovr_o == 0,
          "R1 reset", {done, crc_ok, ferr_o, ovr_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: ticks with no byte
    quiet_gap(100, "R11 idle");

    // R5: known request frame
    fb[0] = 8'h01; fb[1] = 8'h03; fb[2] = 8'h00; fb[3] = 8'h00; fb[4] = 8'h00; fb[5] = 8'h0A;
    check(ref_crc(6) == 16'hCDC5, "R5 ref crc", ref_crc(6), 16'hCDC5);
    fb[6] = 8'hC5; fb[7] = 8'hCD;
    push_frame(8, 5, -1, -1);
    close_frame(8, 0, 0, "R5 known");

    // R4: clock cycles without ticks
    send(8'h11, 0, 0);
    repeat (3000) @(negedge clk);
    check(done == 0, "R4 no tick", done, 0);
    fb[0] = 8'h11;
    close_frame(1, 0, 0, "R4 close");

    // R3: maximal sub-threshold gaps
    build(4, 1);
    for (int k = 0; k < 6; k++) begin
      send(fb[k], 0, 0);
      if (k != 5) quiet_gap(exp_ticks - 1, "R3 max gap");
    end
    close_frame(6, 0, 0, "R3 merged");

    // R6: short frames with zero remainder
    fb[0] = 8'hFF; fb[1] = 8'hFF;
    push_frame(2, 3, -1, -1);
    close_frame(2, 0, 0, "R6 len2");
    build(1, 1);
    push_frame(3, 3, -1, -1);
    close_frame(3, 0, 0, "R6 len3");
    build(2, 1);
    push_frame(4, 3, -1, -1);
    close_frame(4, 0, 0, "R6 len4");

    // R8 / R9 / R10
    build(5, 1);
    push_frame(7, 4, 2, -1);
    close_frame(7, 1, 0, "R8 ferr good crc");
    build(5, 1);
    push_frame(7, 4, -1, 6);
    close_frame(7, 0, 1, "R9 ovr good crc");
    build(3, 0);
    push_frame(5, 4, -1, -1);
    close_frame(5, 0, 0, "R10 fresh bad crc");

    // random frames
    for (int f = 0; f < 40; f++) begin
      int nd, fa, oa;
      bit g;
      nd = $urandom_range(0, 12);
      g  = ($urandom_range(0, 3) != 0);
      fa = ($urandom_range(0, 7) == 0) ? $urandom_range(0, nd + 1) : -1;
      oa = ($urandom_range(0, 7) == 0) ? $urandom_range(0, nd + 1) : -1;
      build(nd, g);
      push_frame(nd + 2, exp_ticks - 1, fa, oa);
      close_frame(nd + 2, fa >= 0, oa >= 0, "R10 random");
    end

    quiet_gap(60, "R11 after frames");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule